// File: doc/BRIEF.md
# Calendar Alarm and Periodic Interrupt Unit

This unit sits next to a calendar counter and turns its progress into interrupts. The counter is outside the block. It delivers its six current fields as BCD bytes (seconds, minutes, hours, day, month, year) together with one rollover strobe each for the second, minute, hour and day periods. The unit holds six alarm match bytes that use the same field layout. It keeps a status byte of event flags and drives one registered interrupt line.

Software reaches the unit through a simple register port. The write port is `wr_en`/`wr_addr`/`wr_data`. The read port is `rd_addr`/`rd_data`, and it is combinational. Two kinds of interrupt exist:
- a recurring timer event, whose period (second, minute, hour or day) is chosen by a 2-bit selector;
- an alarm that latches when the time reaches the programmed match value.

Both are gated by their own enable bits. Status flags are write-1-to-clear. An alarm flag that is left uncleared keeps the interrupt line asserted.

Top module: `rtc_event_irq`

## Requirements
- R1: After reset, every alarm byte, the control byte, the status byte and `irq_o` read as 0.
- R2: Addresses 0 to 5 hold the alarm bytes for seconds, minutes, hours, day, month and year, in that order, and read back as written. Address 6 is control: bits [1:0] are the period selector, bit 2 is the timer enable and bit 3 is the alarm enable. Bits [7:4] of the control byte read 0.
- R3: A rollover strobe for second, minute, hour or day sets status bit 2, 3, 4 or 5 respectively (status is at address 7). The flag is readable in the cycle after the strobe.
- R4: Status bit 6 (the alarm flag) sets one cycle after all six time fields first become equal to the alarm bytes. It does not set again while the equality persists. It does not set for an equality that is already present when reset releases, nor for a mismatch in any single field.
- R5: A write to status clears exactly the flags written as 1 and leaves the others unchanged. Bits 0, 1 and 7 of that write have no effect.
- R6: When a flag is set by an event and cleared by a write in the same cycle, the flag ends up set.
- R7: The alarm flag stays set until software writes 1 to bit 6. While it is set and the alarm is enabled, `irq_o` stays high. `irq_o` rises again when the alarm enable is re-applied to a still-set flag.
- R8: `irq_o` is registered. It equals the previous cycle's (timer enable AND the flag chosen by the selector) OR (alarm enable AND alarm flag). Selector 00 chooses the second flag, 01 the minute flag, 10 the hour flag and 11 the day flag.
- R9: Event and alarm flags are set whether or not their interrupts are enabled, and a masked flag leaves `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | 48 | Current time fields, BCD. Seconds in [7:0], then minutes, hours, day, month; year in [47:40] |
| tick_i | input | 4 | Rollover strobes: bit 0 second, 1 minute, 2 hour, 3 day |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is the alarm edge rule. The flag must latch on the first cycle of equality but stay clear after software clears it while the fields still match. An equality present at reset release must also be ignored. The stimulus holds the reset with the time and alarm both at zero. Later it parks the time on the alarm value, clears the flag mid-equality and watches it stay low. It then steps one field away and back to force a fresh match. Same-cycle strobe-and-clear collisions are produced by driving a rollover strobe and a status write on the same clock edge.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  parameter int unsigned FIELD_W_DEF = 8;   // one BCD byte per time field
  parameter int unsigned NFIELD_DEF  = 6;   // seconds .. year
  parameter int unsigned NPERIOD_DEF = 4;   // second, minute, hour, day
  parameter int unsigned EVT_LSB     = 2;   // first event flag bit in status

  // Period selector encoding
  typedef enum logic [1:0] {
    PER_SEC  = 2'b00,
    PER_MIN  = 2'b01,
    PER_HOUR = 2'b10,
    PER_DAY  = 2'b11
  } period_e;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int unsigned NFIELD  = 6,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [FIELD_W-1:0]        wr_data,
  input  logic [NFIELD*FIELD_W-1:0] time_i,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [FIELD_W-1:0]        rd_field,
  output logic                      alarm_hit
);
  logic [FIELD_W-1:0] alm_q [NFIELD];
  logic [FIELD_W-1:0] alm_d [NFIELD];
  logic [NFIELD-1:0]  fld_eq;
  logic               match;
  logic               match_q;

  // One match byte per field; the write address selects the field.
  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    always_comb begin
      alm_d[f] = alm_q[f];
      if (wr_en && (wr_addr == ADDR_W'(f))) alm_d[f] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm_q[f] <= '0;
      else        alm_q[f] <= alm_d[f];
    end

    assign fld_eq[f] = (alm_q[f] == time_i[f*FIELD_W +: FIELD_W]);
  end

  assign match = &fld_eq;

  // Reset to "already matching" so that an equality present at reset
  // release is not reported as a new one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b1;
    else        match_q <= match;
  end

  assign alarm_hit = match & ~match_q;

  always_comb begin
    rd_field = '0;
    for (int i = 0; i < NFIELD; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_field = alm_q[i];
    end
  end
endmodule

// File: rtl/rtc_evt_status.sv
module rtc_evt_status #(
  parameter int unsigned NPERIOD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPERIOD-1:0] tick_i,
  input  logic               alarm_hit,
  input  logic [NPERIOD-1:0] clr_evt,
  input  logic               clr_alm,
  output logic [NPERIOD-1:0] evt_q,
  output logic               alm_q
);
  logic [NPERIOD-1:0] evt_d;
  logic               alm_d;

  // Set has priority over a same-cycle clear so no event is lost.
  always_comb begin
    evt_d = (evt_q & ~clr_evt) | tick_i;
    alm_d = (alm_q & ~clr_alm) | alarm_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      alm_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      alm_q <= alm_d;
    end
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int unsigned NPERIOD = 4,
  localparam int unsigned SEL_W  = (NPERIOD > 1) ? $clog2(NPERIOD) : 1,
  localparam int unsigned CTRL_W = SEL_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic [CTRL_W-1:0]  ctrl_wdata,
  input  logic [NPERIOD-1:0] evt_q,
  input  logic               alm_flag,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic               irq_o
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [SEL_W-1:0]  sel;
  logic              tmr_en;
  logic              alm_en;
  logic              irq_d;

  // Clock enable on the control register is the write strobe.
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign sel    = ctrl_q[SEL_W-1:0];
  assign tmr_en = ctrl_q[SEL_W];
  assign alm_en = ctrl_q[SEL_W+1];

  always_comb begin
    irq_d = alm_en & alm_flag;
    for (int p = 0; p < NPERIOD; p++) begin
      if (sel == SEL_W'(p)) irq_d = irq_d | (tmr_en & evt_q[p]);
    end
  end

  // Registered output: a clean level for an edge-sensitive receiver.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end
endmodule

// File: rtl/rtc_event_irq.sv
module rtc_event_irq #(
  parameter int unsigned NFIELD  = rtc_irq_pkg::NFIELD_DEF,
  parameter int unsigned FIELD_W = rtc_irq_pkg::FIELD_W_DEF,
  parameter int unsigned NPERIOD = rtc_irq_pkg::NPERIOD_DEF,
  localparam int unsigned ADDR_W = $clog2(NFIELD + 2),
  localparam int unsigned TIME_W = NFIELD * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIME_W-1:0]  time_i,
  input  logic [NPERIOD-1:0] tick_i,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [FIELD_W-1:0] rd_data,
  output logic               irq_o
);
  localparam int unsigned SEL_W    = (NPERIOD > 1) ? $clog2(NPERIOD) : 1;
  localparam int unsigned CTRL_W   = SEL_W + 2;
  localparam int unsigned EVT_LSB  = rtc_irq_pkg::EVT_LSB;
  localparam int unsigned ALM_BIT  = EVT_LSB + NPERIOD;
  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(NFIELD);
  localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(NFIELD + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [FIELD_W-1:0] alm_rd;
  logic               alarm_hit;
  logic [NPERIOD-1:0] evt_q;
  logic               alm_flag;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               stat_we;
  logic               ctrl_we;
  logic [NPERIOD-1:0] clr_evt;
  logic               clr_alm;

  assign stat_we = wr_en && (wr_addr == ADR_STAT);
  assign ctrl_we = wr_en && (wr_addr == ADR_CTRL);
  assign clr_evt = stat_we ? wr_data[EVT_LSB +: NPERIOD] : '0;
  assign clr_alm = stat_we & wr_data[ALM_BIT];

  rtc_alarm_match #(
    .NFIELD (NFIELD),
    .FIELD_W(FIELD_W),
    .ADDR_W (ADDR_W)
  ) u_match (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .time_i   (time_i),
    .rd_addr  (rd_addr),
    .rd_field (alm_rd),
    .alarm_hit(alarm_hit)
  );

  rtc_evt_status #(
    .NPERIOD(NPERIOD)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_i   (tick_i),
    .alarm_hit(alarm_hit),
    .clr_evt  (clr_evt),
    .clr_alm  (clr_alm),
    .evt_q    (evt_q),
    .alm_q    (alm_flag)
  );

  rtc_irq_ctrl #(
    .NPERIOD(NPERIOD)
  ) u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_we   (ctrl_we),
    .ctrl_wdata(wr_data[CTRL_W-1:0]),
    .evt_q     (evt_q),
    .alm_flag  (alm_flag),
    .ctrl_q    (ctrl_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_data = alm_rd;
    if (rd_addr == ADR_CTRL) begin
      rd_data = '0;
      rd_data[CTRL_W-1:0] = ctrl_q;
    end else if (rd_addr == ADR_STAT) begin
      rd_data = '0;
      rd_data[EVT_LSB +: NPERIOD] = evt_q;
      rd_data[ALM_BIT] = alm_flag;
    end
  end
endmodule

// File: rtl/rtc_event_irq_chk.sv
module rtc_event_irq_chk #(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned NPERIOD = 4,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned STAT_AD = 7,
  parameter int unsigned CTRL_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPERIOD-1:0] tick_i,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [FIELD_W-1:0] wr_data,
  input logic [NPERIOD-1:0] evt_q,
  input logic               alm_q,
  input logic [CTRL_W-1:0]  ctrl_q,
  input logic               irq_o
);
  localparam int unsigned EVT_LSB = rtc_irq_pkg::EVT_LSB;
  localparam int unsigned ALM_BIT = EVT_LSB + NPERIOD;

  logic stat_wr;
  assign stat_wr = wr_en && (wr_addr == ADDR_W'(STAT_AD));

  for (genvar p = 0; p < NPERIOD; p++) begin : g_per
    // R3 / R6: a strobe always leaves its flag set
    a_r3_tick_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i[p] |=> evt_q[p]);
    // R5: writing 1 clears the flag when no strobe competes
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wr_data[EVT_LSB+p] && !tick_i[p]) |=> !evt_q[p]);
    // R5: a flag not written as 1 keeps its value
    a_r5_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q[p] && !(stat_wr && wr_data[EVT_LSB+p])) |=> evt_q[p]);
  end

  // R7: alarm flag only leaves by a 1 written to its bit
  a_r7_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_q && !(stat_wr && wr_data[ALM_BIT])) |=> alm_q);

  // R7: enabled alarm flag keeps the line high
  a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTRL_W-1] && alm_q) |=> irq_o);

  // R9: with both enables off the line stays low
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTRL_W-1:CTRL_W-2] == 2'b00) |=> !irq_o);
endmodule

bind rtc_event_irq rtc_event_irq_chk #(
  .FIELD_W(FIELD_W),
  .NPERIOD(NPERIOD),
  .ADDR_W (ADDR_W),
  .STAT_AD(NFIELD + 1),
  .CTRL_W (CTRL_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .tick_i (tick_i),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .evt_q  (evt_q),
  .alm_q  (alm_flag),
  .ctrl_q (ctrl_q),
  .irq_o  (irq_o)
);

// File: tb/sim_rtc_event_irq.sv
`timescale 1ns/100ps
module sim_rtc_event_irq;
  localparam logic [2:0] A_CTRL = 3'd6;
  localparam logic [2:0] A_STAT = 3'd7;
  localparam logic [47:0] T_START = {8'h26, 8'h04, 8'h07, 8'h10, 8'h15, 8'h29};
  localparam logic [47:0] T_ALM   = {8'h26, 8'h04, 8'h07, 8'h10, 8'h15, 8'h30};
  localparam logic [47:0] T_NEXT  = {8'h26, 8'h04, 8'h07, 8'h10, 8'h15, 8'h31};
  localparam logic [47:0] T_YEAR  = {8'h27, 8'h04, 8'h07, 8'h10, 8'h15, 8'h30};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] time_i;
  logic [3:0]  tick_i;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [2:0]  rd_addr;
  logic [7:0]  rd_data;
  logic        irq_o;

  always #5 clk = ~clk;

  rtc_event_irq u0 (
    .clk(clk), .rst_n(rst_n), .time_i(time_i), .tick_i(tick_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sb_ev;
  int       checks = 0;
  int       failures = 0;
  bit       done = 1'b0;

  // Monitor: pops each expectation and compares it with the ports.
  initial begin
    forever begin
      @(sb_ev);
      #0.1;
      while (sb_q.size() != 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (it.is_irq) begin
          if (irq_o !== it.exp[0]) begin
            failures++;
            $display("FAIL %s irq_o actual=%0b expected=%0b", it.tag, irq_o, it.exp[0]);
          end
        end else if (rd_data !== it.exp) begin
          failures++;
          $display("FAIL %s addr=%0d actual=%02h expected=%02h", it.tag, rd_addr, rd_data, it.exp);
        end
      end
    end
  end

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    rd_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> sb_ev;
    #0.2;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    sb_item_t it;
    it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    -> sb_ev;
    #0.2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    tick_i = m;
    @(negedge clk);
    tick_i = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; time_i = '0; tick_i = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 and R4: reset state, with time equal to the all-zero alarm
    chk_rd(3'd0, 8'h00, "R1 alarm sec");
    chk_rd(3'd5, 8'h00, "R1 alarm year");
    chk_rd(A_CTRL, 8'h00, "R1 ctrl");
    chk_rd(A_STAT, 8'h00, "R1/R4 status after reset with matching time");
    chk_irq(1'b0, "R1 irq");
    time_i = T_START;
    idle(2);

    // R2: alarm bytes and control readback
    for (int f = 0; f < 6; f++) wr_reg(3'(f), T_ALM[f*8 +: 8]);
    for (int f = 0; f < 6; f++) chk_rd(3'(f), T_ALM[f*8 +: 8], "R2 alarm field");
    wr_reg(A_CTRL, 8'hF6);
    chk_rd(A_CTRL, 8'h06, "R2 ctrl upper bits read 0");
    wr_reg(A_CTRL, 8'h00);

    // R3, R9: strobes set flags with interrupts masked
    pulse(4'b0001);
    chk_rd(A_STAT, 8'h04, "R3 second flag");
    pulse(4'b1110);
    chk_rd(A_STAT, 8'h3C, "R3 minute/hour/day flags");
    idle(1);
    chk_irq(1'b0, "R9 masked flags keep irq low");

    // R5: write-1-to-clear of exactly the written bits
    wr_reg(A_STAT, 8'h8B);
    chk_rd(A_STAT, 8'h34, "R5 clear minute only");
    wr_reg(A_STAT, 8'h34);
    chk_rd(A_STAT, 8'h00, "R5 clear rest");

    // R6: strobe and clear in the same cycle
    tick_i = 4'b0001; wr_en = 1'b1; wr_addr = A_STAT; wr_data = 8'h04;
    @(negedge clk);
    tick_i = '0; wr_en = 1'b0;
    chk_rd(A_STAT, 8'h04, "R6 set wins over clear");
    wr_reg(A_STAT, 8'h3C);

    // R8: each selector value
    for (int s = 0; s < 4; s++) begin
      wr_reg(A_CTRL, 8'(4 | s));
      pulse(4'(1 << ((s + 1) % 4)));
      idle(1);
      chk_irq(1'b0, "R8 unselected period quiet");
      pulse(4'(1 << s));
      chk_irq(1'b0, "R8 irq registered, not yet high");
      idle(1);
      chk_irq(1'b1, "R8 selected period raises irq");
      wr_reg(A_STAT, 8'h3C);
      chk_irq(1'b1, "R8 irq one cycle behind clear");
      idle(1);
      chk_irq(1'b0, "R8 irq low after clear");
    end
    wr_reg(A_CTRL, 8'h08);

    // R4: alarm match timing and single fire
    time_i = T_ALM;
    @(negedge clk);
    chk_rd(A_STAT, 8'h40, "R4 alarm flag on first equality");
    chk_irq(1'b0, "R8 alarm irq one cycle later");
    idle(1);
    chk_irq(1'b1, "R7 alarm irq high");
    wr_reg(A_STAT, 8'h40);
    idle(4);
    chk_rd(A_STAT, 8'h00, "R4 no re-fire while still equal");
    chk_irq(1'b0, "R4 irq low after clear");

    // R4: a single differing field never matches
    time_i = T_YEAR;
    idle(3);
    chk_rd(A_STAT, 8'h00, "R4 year mismatch no alarm");

    // R7: sticky alarm flag and level interrupt
    time_i = T_NEXT;
    @(negedge clk);
    time_i = T_ALM;
    @(negedge clk);
    time_i = T_NEXT;
    idle(20);
    chk_rd(A_STAT, 8'h40, "R7 alarm flag held");
    chk_irq(1'b1, "R7 irq held");
    wr_reg(A_STAT, 8'hBC);
    chk_rd(A_STAT, 8'h40, "R5 alarm untouched by other bits");
    wr_reg(A_CTRL, 8'h00);
    idle(1);
    chk_irq(1'b0, "R9 alarm masked");
    chk_rd(A_STAT, 8'h40, "R9 flag kept while masked");
    wr_reg(A_CTRL, 8'h08);
    chk_irq(1'b0, "R7 enable registered");
    idle(1);
    chk_irq(1'b1, "R7 irq re-raised on enable");
    wr_reg(A_STAT, 8'h40);
    idle(1);
    chk_irq(1'b0, "R7 irq low after clear");
    chk_rd(A_STAT, 8'h00, "R7 flag cleared by write");

    done = 1'b1;
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule